// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small accumulator processor. Each cycle in which `op_valid` is high it takes an operation code, a left operand (normally the accumulator or a memory byte), a right operand and the current status byte. One clock later it presents the 8-bit result, the updated status byte and a write-back enable. The surrounding core fetches operands, decodes instructions and stores results. The ALU only computes values and flags.

Subtraction and compare reuse the single adder with the right operand inverted, so carry means "no borrow". The adder also produces a half-carry from the low nibble and a signed-overflow flag. The unit also covers logic operations, increment and decrement, the four single-bit shifts and rotates, a one-cycle nibble exchange, and the carry and overflow flag operations. The status byte is packed as N=bit7, V=bit6, P=bit5, B=bit4, H=bit3, I=bit2, Z=bit1, C=bit0. P, B and I always pass through unchanged.

Top module: `alu8_flags`

## Requirements
- R1: While `rst_n` is low, `res_out`, `psw_out`, `wb_en` and `out_valid` are all 0.
- R2: An operation presented with `op_valid`=1 at a rising edge appears on the outputs after that edge, with `out_valid`=1. A cycle with `op_valid`=0 gives `out_valid`=0 and `wb_en`=0 after the next edge.
- R3: Code 0 (add with carry) gives res = lhs+rhs+C mod 256. C is the carry out of bit 7, H is the carry out of bit 3 (including carry-in), V is the signed overflow, and N and Z come from the result. `wb_en`=1.
- R4: Code 1 (subtract with borrow) gives res = lhs+(~rhs)+C mod 256. Flags are set as in R3, so C=1 means no borrow. `wb_en`=1.
- R5: Code 2 (compare) sets N and Z from lhs-rhs mod 256 and sets C=1 when lhs>=rhs (unsigned). V and H are unchanged, `wb_en`=0 and `res_out`=0.
- R6: Codes 3 (AND), 4 (OR) and 5 (exclusive OR) write lhs op rhs and update only N and Z.
- R7: Codes 6 (increment) and 7 (decrement) write lhs+1 or lhs-1 mod 256 and update only N and Z. C is unchanged.
- R8: Codes 8 (shift left), 9 (shift right), 10 (rotate left) and 11 (rotate right) operate on lhs. Shifts bring in 0 and rotates bring in the old C. The bit shifted out becomes C, N and Z follow the result, and V and H are unchanged.
- R9: Code 12 swaps lhs bits 7:4 with bits 3:0, writes the result and sets N and Z from it.
- R10: Codes 13 (set C), 14 (clear C) and 15 (complement C) change only C. Code 16 clears V and H only. All four have `wb_en`=0 and `res_out`=0.
- R11: For every code, P, B and I of `psw_out` equal those of `psw_in`. When `wb_en`=1, N equals `res_out[7]` and Z is 1 exactly when `res_out` is 0.
- R12: Codes 17 to 31 are undefined: `psw_out` equals `psw_in`, `wb_en`=0 and `res_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| lhs | input | 8 | Left operand |
| rhs | input | 8 | Right operand |
| psw_in | input | 8 | Current status byte |
| res_out | output | 8 | Registered result |
| psw_out | output | 8 | Registered new status byte |
| wb_en | output | 1 | Result must be written back |
| out_valid | output | 1 | Outputs belong to an operation |

## Verification
In one addition, carry out of bit 7, carry out of bit 3 and signed overflow can all arise in the same cycle. Adding 0x88 and 0x88 with carry-in 1 provokes all three: the bench expects result 0x11 with C, H and V all set. Zero and carry together come from 0x80+0x80, which must give Z, C and V set with H clear. A randomized sweep runs against a reference model in the bench and places idle gaps between operations, so a stale result or a stale `out_valid` is caught by the scoreboard.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [4:0] op_code,
  input  logic [7:0] lhs,
  input  logic [7:0] rhs,
  input  logic [7:0] psw_in,
  output logic [7:0] res_out,
  output logic [7:0] psw_out,
  output logic       wb_en,
  output logic       out_valid
);
  localparam logic [4:0] OP_ADC = 5'd0,  OP_SBC = 5'd1,  OP_CMP = 5'd2,  OP_AND = 5'd3;
  localparam logic [4:0] OP_OR  = 5'd4,  OP_EOR = 5'd5,  OP_INC = 5'd6,  OP_DEC = 5'd7;
  localparam logic [4:0] OP_ASL = 5'd8,  OP_LSR = 5'd9,  OP_ROL = 5'd10, OP_ROR = 5'd11;
  localparam logic [4:0] OP_XCN = 5'd12, OP_SEC = 5'd13, OP_CLC = 5'd14, OP_CMC = 5'd15;
  localparam logic [4:0] OP_CLV = 5'd16;

  logic       c_old;
  logic [7:0] add_b;
  logic       add_ci;
  logic [8:0] add_sum;
  logic [4:0] add_lo;
  logic       add_ovf;

  assign c_old   = psw_in[0];
  assign add_b   = (op_code == OP_ADC) ? rhs : ~rhs;
  assign add_ci  = (op_code == OP_CMP) ? 1'b1 : c_old;
  assign add_sum = {1'b0, lhs} + {1'b0, add_b} + {8'd0, add_ci};
  assign add_lo  = {1'b0, lhs[3:0]} + {1'b0, add_b[3:0]} + {4'd0, add_ci};
  assign add_ovf = (lhs[7] == add_b[7]) && (add_sum[7] != lhs[7]);

  logic [7:0] r, nzv;
  logic       f_c, f_v, f_h, nz_upd, wb;

  always_comb begin
    r      = 8'd0;
    nzv    = 8'd0;
    f_c    = c_old;
    f_v    = psw_in[6];
    f_h    = psw_in[3];
    nz_upd = 1'b0;
    wb     = 1'b0;
    case (op_code)
      OP_ADC, OP_SBC: begin
        r = add_sum[7:0]; f_c = add_sum[8]; f_h = add_lo[4]; f_v = add_ovf;
        nz_upd = 1'b1; wb = 1'b1;
      end
      OP_CMP: begin nzv = add_sum[7:0]; f_c = add_sum[8]; nz_upd = 1'b1; end
      OP_AND: begin r = lhs & rhs; nz_upd = 1'b1; wb = 1'b1; end
      OP_OR:  begin r = lhs | rhs; nz_upd = 1'b1; wb = 1'b1; end
      OP_EOR: begin r = lhs ^ rhs; nz_upd = 1'b1; wb = 1'b1; end
      OP_INC: begin r = lhs + 8'd1; nz_upd = 1'b1; wb = 1'b1; end
      OP_DEC: begin r = lhs - 8'd1; nz_upd = 1'b1; wb = 1'b1; end
      OP_ASL: begin r = {lhs[6:0], 1'b0};  f_c = lhs[7]; nz_upd = 1'b1; wb = 1'b1; end
      OP_LSR: begin r = {1'b0, lhs[7:1]};  f_c = lhs[0]; nz_upd = 1'b1; wb = 1'b1; end
      OP_ROL: begin r = {lhs[6:0], c_old}; f_c = lhs[7]; nz_upd = 1'b1; wb = 1'b1; end
      OP_ROR: begin r = {c_old, lhs[7:1]}; f_c = lhs[0]; nz_upd = 1'b1; wb = 1'b1; end
      OP_XCN: begin r = {lhs[3:0], lhs[7:4]}; nz_upd = 1'b1; wb = 1'b1; end
      OP_SEC: f_c = 1'b1;
      OP_CLC: f_c = 1'b0;
      OP_CMC: f_c = ~c_old;
      OP_CLV: begin f_v = 1'b0; f_h = 1'b0; end
      default: ;
    endcase
    if (wb) nzv = r;
  end

  logic f_n, f_z;
  assign f_n = nz_upd ? nzv[7] : psw_in[7];
  assign f_z = nz_upd ? (nzv == 8'd0) : psw_in[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_out   <= 8'd0;
      psw_out   <= 8'd0;
      wb_en     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= op_valid;
      wb_en     <= op_valid & wb;
      if (op_valid) begin
        res_out <= r;
        psw_out <= {f_n, f_v, psw_in[5:4], f_h, psw_in[2], f_z, f_c};
      end
    end
  end
endmodule

module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [4:0] op_code,
  input logic [7:0] psw_in,
  input logic [7:0] res_out,
  input logic [7:0] psw_out,
  input logic       wb_en,
  input logic       out_valid
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> out_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!out_valid && !wb_en));
  p_cmp_keeps_vh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'd2) |=>
      (!wb_en && psw_out[6] == $past(psw_in[6]) && psw_out[3] == $past(psw_in[3])));
  p_incdec_keep_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 5'd6 || op_code == 5'd7)) |=> psw_out[0] == $past(psw_in[0]));
  p_fixed_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (psw_out[5:4] == $past(psw_in[5:4]) && psw_out[2] == $past(psw_in[2])));
  p_n_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> psw_out[7] == res_out[7]);
  p_z_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> psw_out[1] == (res_out == 8'd0));
  p_undef_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > 5'd16) |=> (!wb_en && res_out == 8'd0 && psw_out == $past(psw_in)));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .psw_in(psw_in),
  .res_out(res_out), .psw_out(psw_out), .wb_en(wb_en), .out_valid(out_valid)
);

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = 5'd0;
  logic [7:0] lhs = 8'd0, rhs = 8'd0, psw_in = 8'd0;
  logic [7:0] res_out, psw_out;
  logic       wb_en, out_valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  alu8_flags dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .lhs(lhs), .rhs(rhs), .psw_in(psw_in), .res_out(res_out),
    .psw_out(psw_out), .wb_en(wb_en), .out_valid(out_valid)
  );

  // reference: returns {wb, res, psw}
  function automatic logic [16:0] model(input int op, input int l, input int r, input int p);
    int c, s, res, n, v, h, z, wb, upd, nzsrc;
    c = p & 1; v = (p >> 6) & 1; h = (p >> 3) & 1;
    n = (p >> 7) & 1; z = (p >> 1) & 1;
    res = 0; wb = 0; upd = 0; nzsrc = 0;
    case (op)
      0, 1: begin
        int b;
        b = (op == 1) ? (255 - r) : r;
        s = l + b + c;
        h = ((l % 16) + (b % 16) + c) >= 16 ? 1 : 0;
        v = ((l < 128) == (b < 128)) && (((s % 256) < 128) != (l < 128)) ? 1 : 0;
        c = s >= 256 ? 1 : 0;
        res = s % 256; wb = 1; upd = 1;
      end
      2: begin nzsrc = (l - r + 256) % 256; c = (l >= r) ? 1 : 0; upd = 1; end
      3: begin res = l & r; wb = 1; upd = 1; end
      4: begin res = l | r; wb = 1; upd = 1; end
      5: begin res = l ^ r; wb = 1; upd = 1; end
      6: begin res = (l + 1) % 256; wb = 1; upd = 1; end
      7: begin res = (l + 255) % 256; wb = 1; upd = 1; end
      8: begin res = (l * 2) % 256; c = l / 128; wb = 1; upd = 1; end
      9: begin res = l / 2; c = l % 2; wb = 1; upd = 1; end
      10: begin res = (l * 2) % 256 + c; c = l / 128; wb = 1; upd = 1; end
      11: begin res = l / 2 + 128 * c; c = l % 2; wb = 1; upd = 1; end
      12: begin res = (l % 16) * 16 + l / 16; wb = 1; upd = 1; end
      13: c = 1;
      14: c = 0;
      15: c = 1 - c;
      16: begin v = 0; h = 0; end
      default: ;
    endcase
    if (wb == 1) nzsrc = res;
    if (upd == 1) begin n = nzsrc / 128; z = (nzsrc == 0) ? 1 : 0; end
    s = n * 128 + v * 64 + (p & 8'h34) + h * 8 + z * 2 + c;
    model = {wb[0], res[7:0], s[7:0]};
  endfunction

  task automatic send(input int op, input int l, input int r, input int p,
                      input logic [16:0] expv, input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_code = op[4:0]; lhs = l[7:0]; rhs = r[7:0]; psw_in = p[7:0];
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
    op_code = 5'd0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2: out_valid=1 with nothing pending, expected out_valid=0");
        end else begin
          logic [16:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({wb_en, res_out, psw_out} !== e) begin
            errors++;
            $display("FAIL %s: got wb=%0b res=%02h psw=%02h, expected wb=%0b res=%02h psw=%02h",
                     t, wb_en, res_out, psw_out, e[16], e[15:8], e[7:0]);
          end
        end
      end else if (wb_en) begin
        checks++; errors++;
        $display("FAIL R2: wb_en=1 without out_valid, expected 0");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({res_out, psw_out, wb_en, out_valid} !== 18'd0) begin
      errors++;
      $display("FAIL R1: reset outputs %02h %02h %0b %0b, expected all 0",
               res_out, psw_out, wb_en, out_valid);
    end
    @(negedge clk) rst_n = 1'b1;

    // R3 carry, half carry and overflow together; zero with carry
    send(0, 8'h88, 8'h88, 8'h01, {1'b1, 8'h11, 8'h49}, "R3 all-carry");
    send(0, 8'h80, 8'h80, 8'h00, {1'b1, 8'h00, 8'h43}, "R3 zero-carry");
    send(0, 8'h12, 8'h34, 8'h34, {1'b1, 8'h46, 8'h34}, "R11 fixed bits");
    // R4 no borrow / borrow
    send(1, 8'h50, 8'h30, 8'h01, {1'b1, 8'h20, 8'h09}, "R4 no-borrow");
    send(1, 8'h00, 8'h01, 8'h01, {1'b1, 8'hFF, 8'h80}, "R4 borrow");
    // R5 compare
    send(2, 8'h42, 8'h42, 8'h48, {1'b0, 8'h00, 8'h4B}, "R5 equal");
    send(2, 8'h10, 8'h20, 8'h00, {1'b0, 8'h00, 8'h80}, "R5 less");
    idle();
    // R6 logic keeps C V H
    send(3, 8'hF0, 8'h0F, 8'h49, {1'b1, 8'h00, 8'h4B}, "R6 and-zero");
    send(5, 8'hFF, 8'h0F, 8'h00, {1'b1, 8'hF0, 8'h80}, "R6 eor");
    // R7 wrap
    send(6, 8'hFF, 8'h00, 8'h01, {1'b1, 8'h00, 8'h03}, "R7 inc-wrap");
    send(7, 8'h00, 8'h00, 8'h00, {1'b1, 8'hFF, 8'h80}, "R7 dec-wrap");
    // R8 shifts and rotates
    send(8, 8'h81, 8'h00, 8'h00, {1'b1, 8'h02, 8'h01}, "R8 asl");
    send(9, 8'h01, 8'h00, 8'h01, {1'b1, 8'h00, 8'h03}, "R8 lsr");
    send(10, 8'h80, 8'h00, 8'h01, {1'b1, 8'h01, 8'h01}, "R8 rol");
    send(11, 8'h02, 8'h00, 8'h01, {1'b1, 8'h81, 8'h80}, "R8 ror");
    idle();
    idle();
    // R9 nibble swap
    send(12, 8'hA5, 8'h00, 8'h00, {1'b1, 8'h5A, 8'h00}, "R9 swap");
    send(12, 8'h80, 8'h00, 8'h82, {1'b1, 8'h08, 8'h00}, "R9 swap-flags");
    // R10 flag ops
    send(13, 8'h00, 8'h00, 8'hF2, {1'b0, 8'h00, 8'hF3}, "R10 setc");
    send(14, 8'h55, 8'h00, 8'hFF, {1'b0, 8'h00, 8'hFE}, "R10 clrc");
    send(15, 8'h00, 8'h00, 8'h01, {1'b0, 8'h00, 8'h00}, "R10 notc");
    send(16, 8'h00, 8'h00, 8'hFF, {1'b0, 8'h00, 8'hB7}, "R10 clrv");
    // R12 undefined
    send(20, 8'h77, 8'h33, 8'hA5, {1'b0, 8'h00, 8'hA5}, "R12 undefined");
    idle();

    // randomized sweep with gaps (R2..R12)
    for (int i = 0; i < 400; i++) begin
      int op, l, r, p;
      op = $urandom_range(0, 22);
      l = $urandom_range(0, 255);
      r = $urandom_range(0, 255);
      p = $urandom_range(0, 255);
      send(op, l, r, p, model(op, l, r, p), $sformatf("R3-R12 sweep op=%0d", op));
      if ($urandom_range(0, 3) == 0) idle();
    end
    idle();
    idle();
    idle();

    checks++;
    if (exp_q.size() != 0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2: pending=%0d out_valid=%0b, expected 0 and 0", exp_q.size(), out_valid);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule